// File: doc/BRIEF.md
# CPU Pointer and Stack Register Unit

This block keeps the address-generating registers of a small 8-bit processor core. It holds two RAM data pointers, a stack pointer and a 15-bit program counter. Each cycle it presents one RAM address, taken from the stack pointer during a push or pop and otherwise from the selected data pointer. A pointer access may step the pointer up or down by one after its use. The program counter counts, takes full or low-byte jumps, and moves to one shared vector address when an interrupt is taken.

The data pointers and the stack pointer can be read and written through a small register port. The program counter cannot be reached through that port. Instruction decode and arithmetic live elsewhere and drive this block through single-cycle strobes.

Top module: `ptr_stack_unit`

## Requirements
- R1: While reset is low and in the first cycle after it rises, the stack pointer holds 0x6F, both data pointers hold 0x00 and the program counter holds 0x0000.
- R2: Register port codes are 0 for the first data pointer, 1 for the second data pointer and 2 for the stack pointer. Code 3 reads 0x00 and a write to it changes nothing. A read is combinational. A write becomes visible in the cycle after its strobe.
- R3: With no single stack operation, ram_addr equals the data pointer chosen by ptr_sel (0 = first, 1 = second) in the same cycle. When ptr_access is high, ptr_mode 01 adds one to that pointer, 10 subtracts one, and 00 or 11 leave it unchanged. The new value appears in the next cycle.
- R4: Data pointer and stack pointer steps wrap modulo 256.
- R5: A register-port write to a pointer in the same cycle as that pointer's own step wins, and the written value is stored. This holds for the stack pointer during a push or pop and for a data pointer during a stepped access.
- R6: During a push alone, ram_addr equals the stack pointer and the stack pointer is one lower in the next cycle.
- R7: During a pop alone, ram_addr equals the stack pointer plus one and the stack pointer is one higher in the next cycle.
- R8: While exactly one of push or pop is high, ptr_access has no effect on any data pointer. Push and pop together leave the stack pointer unchanged and hand ram_addr back to the data pointer path.
- R9: pc_inc adds one to the program counter modulo 2^15.
- R10: irq_take loads the program counter with 0x00FF and takes priority over every other program counter control.
- R11: pc_load loads all 15 bits from pc_load_val. pc_lo_load replaces bits 7..0 with pc_lo_val and keeps bits 14..8. The order of priority is irq_take, then pc_load, then pc_lo_load, then pc_inc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_addr | input | 2 | Register port code |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| ptr_access | input | 1 | Data pointer access this cycle |
| ptr_sel | input | 1 | Data pointer select |
| ptr_mode | input | 2 | Post-step mode of the access |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| pc_inc | input | 1 | Program counter increment |
| pc_load | input | 1 | Full program counter load |
| pc_load_val | input | 15 | Full load value |
| pc_lo_load | input | 1 | Low-byte program counter load |
| pc_lo_val | input | 8 | Low-byte load value |
| irq_take | input | 1 | Interrupt entry |
| ram_addr | output | 8 | RAM address for this cycle |
| pc | output | 15 | Program counter |

## Verification
ram_addr and reg_rdata are combinational, so they are due in the same cycle as the select inputs and reflect the register state left by the previous edge. Every pointer, stack and program counter update is due exactly one edge after its strobe. The bench drives inputs just after the falling edge and compares all three outputs with its reference model a quarter period later. It advances the model at the rising edge, so each register effect is checked in the first cycle it can be seen.

// File: rtl/ptr_stack_pkg.sv
package ptr_stack_pkg;
   typedef enum logic [1:0] {
      STEP_NONE = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10,
      STEP_KEEP = 2'b11
   } step_e;

   typedef enum logic [1:0] {
      STK_IDLE  = 2'b00,
      STK_PUSH  = 2'b01,
      STK_POP   = 2'b10,
      STK_CLASH = 2'b11
   } stk_op_e;
endpackage

// File: rtl/psu_ram_ptr.sv
module psu_ram_ptr
   import ptr_stack_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         step_en,
   input  step_e        step,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (step_en) begin
         unique case (step)
            STEP_INC: nxt = q + W'(1);
            STEP_DEC: nxt = q - W'(1);
            default:  nxt = q;
         endcase
      end
      if (wr_en) nxt = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/psu_stack_ptr.sv
module psu_stack_ptr
   import ptr_stack_pkg::*;
#(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = 8'h6F,
   parameter bit GROW_DOWN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  stk_op_e      op,
   output logic [W-1:0] sp,
   output logic [W-1:0] op_addr
);
   logic [W-1:0] sp_plus, sp_minus, on_push, on_pop, nxt;

   assign sp_plus  = sp + W'(1);
   assign sp_minus = sp - W'(1);

   generate
      if (GROW_DOWN) begin : g_down
         assign on_push = sp_minus;
         assign on_pop  = sp_plus;
         assign op_addr = (op == STK_POP) ? sp_plus : sp;
      end else begin : g_up
         assign on_push = sp_plus;
         assign on_pop  = sp_minus;
         assign op_addr = (op == STK_POP) ? sp_minus : sp;
      end
   endgenerate

   always_comb begin
      unique case (op)
         STK_PUSH: nxt = on_push;
         STK_POP:  nxt = on_pop;
         default:  nxt = sp;
      endcase
      if (wr_en) nxt = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp <= RST_VAL;
      else        sp <= nxt;
   end
endmodule

// File: rtl/psu_prog_ctr.sv
module psu_prog_ctr #(
   parameter int unsigned PC_W = 15,
   parameter int unsigned LO_W = 8,
   parameter logic [PC_W-1:0] VEC = 15'h00FF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_take,
   input  logic            load,
   input  logic [PC_W-1:0] load_val,
   input  logic            lo_load,
   input  logic [LO_W-1:0] lo_val,
   input  logic            inc,
   output logic [PC_W-1:0] pc
);
   localparam int unsigned HI_W = PC_W - LO_W;

   logic [PC_W-1:0] nxt;

   always_comb begin
      if (irq_take)     nxt = VEC;
      else if (load)    nxt = load_val;
      else if (lo_load) nxt = {pc[PC_W-1 -: HI_W], lo_val};
      else if (inc)     nxt = pc + PC_W'(1);
      else              nxt = pc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= nxt;
   end
endmodule

// File: rtl/ptr_stack_unit.sv
module ptr_stack_unit
   import ptr_stack_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PC_W      = 15,
   parameter int unsigned NUM_PTR   = 2,
   parameter logic [DATA_W-1:0] SP_RESET  = 8'h6F,
   parameter logic [DATA_W-1:0] PTR_RESET = 8'h00,
   parameter logic [PC_W-1:0]   IRQ_VEC   = 15'h00FF,
   parameter bit GROW_DOWN = 1'b1,
   localparam int unsigned RA_W = $clog2(NUM_PTR + 2),
   localparam int unsigned PS_W = $clog2(NUM_PTR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ptr_access,
   input  logic [PS_W-1:0]   ptr_sel,
   input  logic [1:0]        ptr_mode,
   input  logic              push,
   input  logic              pop,
   input  logic              pc_inc,
   input  logic              pc_load,
   input  logic [PC_W-1:0]   pc_load_val,
   input  logic              pc_lo_load,
   input  logic [DATA_W-1:0] pc_lo_val,
   input  logic              irq_take,
   output logic [DATA_W-1:0] ram_addr,
   output logic [PC_W-1:0]   pc
);
   localparam logic [RA_W-1:0] SP_IDX = RA_W'(NUM_PTR);

   generate
      if (NUM_PTR < 2) begin : g_bad_nptr
         $error("NUM_PTR must be at least 2");
      end
      if (PC_W <= DATA_W) begin : g_bad_pcw
         $error("PC_W must exceed DATA_W");
      end
   endgenerate

   stk_op_e          stk_op;
   logic             stk_busy;
   logic [DATA_W-1:0] sp_val, stk_addr, sel_ptr;
   logic [DATA_W-1:0] ptr_val [NUM_PTR];
   step_e            step;

   assign stk_op   = stk_op_e'({pop, push});
   assign stk_busy = (stk_op == STK_PUSH) || (stk_op == STK_POP);
   assign step     = step_e'(ptr_mode);

   genvar g;
   generate
      for (g = 0; g < NUM_PTR; g++) begin : g_ptr
         psu_ram_ptr #(.W(DATA_W), .RST_VAL(PTR_RESET)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr_en && (reg_addr == RA_W'(g))),
            .wr_data (reg_wdata),
            .step_en (ptr_access && !stk_busy && (ptr_sel == PS_W'(g))),
            .step    (step),
            .q       (ptr_val[g])
         );
      end
   endgenerate

   psu_stack_ptr #(.W(DATA_W), .RST_VAL(SP_RESET), .GROW_DOWN(GROW_DOWN)) u_sp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en && (reg_addr == SP_IDX)),
      .wr_data (reg_wdata),
      .op      (stk_op),
      .sp      (sp_val),
      .op_addr (stk_addr)
   );

   psu_prog_ctr #(.PC_W(PC_W), .LO_W(DATA_W), .VEC(IRQ_VEC)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_take (irq_take),
      .load     (pc_load),
      .load_val (pc_load_val),
      .lo_load  (pc_lo_load),
      .lo_val   (pc_lo_val),
      .inc      (pc_inc),
      .pc       (pc)
   );

   always_comb begin
      sel_ptr = ptr_val[0];
      for (int i = 1; i < NUM_PTR; i++)
         if (ptr_sel == PS_W'(i)) sel_ptr = ptr_val[i];
   end

   assign ram_addr = stk_busy ? stk_addr : sel_ptr;

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_PTR; i++)
         if (reg_addr == RA_W'(i)) reg_rdata = ptr_val[i];
      if (reg_addr == SP_IDX) reg_rdata = sp_val;
   end
endmodule

// File: rtl/psu_chk.sv
module psu_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PC_W   = 15,
   parameter logic [PC_W-1:0] IRQ_VEC = 15'h00FF
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              ptr_access,
   input logic              ptr_sel,
   input logic [1:0]        ptr_mode,
   input logic              push,
   input logic              pop,
   input logic              pc_inc,
   input logic              pc_load,
   input logic              pc_lo_load,
   input logic              irq_take,
   input logic [DATA_W-1:0] ram_addr,
   input logic [PC_W-1:0]   pc,
   input logic [DATA_W-1:0] sp_q,
   input logic [DATA_W-1:0] p0_q
);
   // R2
   unused_code_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd3) |-> (reg_rdata == '0));

   // R3
   post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_access && !(push ^ pop) && !ptr_sel && ptr_mode == 2'b01 &&
       !(reg_wr_en && reg_addr == 2'd0))
      |=> (p0_q == DATA_W'($past(p0_q) + 1'b1)));

   // R5
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr == 2'd0) |=> (p0_q == $past(reg_wdata)));

   // R6
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (ram_addr == sp_q));

   // R6
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !(reg_wr_en && reg_addr == 2'd2))
      |=> (sp_q == DATA_W'($past(sp_q) - 1'b1)));

   // R7
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !(reg_wr_en && reg_addr == 2'd2))
      |=> (sp_q == DATA_W'($past(sp_q) + 1'b1)));

   // R9
   pc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_inc && !pc_load && !pc_lo_load && !irq_take)
      |=> (pc == PC_W'($past(pc) + 1'b1)));

   // R10
   irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> (pc == IRQ_VEC));
endmodule

bind ptr_stack_unit psu_chk #(.DATA_W(DATA_W), .PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr_en  (reg_wr_en),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .ptr_access (ptr_access),
   .ptr_sel    (ptr_sel),
   .ptr_mode   (ptr_mode),
   .push       (push),
   .pop        (pop),
   .pc_inc     (pc_inc),
   .pc_load    (pc_load),
   .pc_lo_load (pc_lo_load),
   .irq_take   (irq_take),
   .ram_addr   (ram_addr),
   .pc         (pc),
   .sp_q       (sp_val),
   .p0_q       (ptr_val[0])
);

// File: tb/ptr_stack_unit_test.sv
module ptr_stack_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        ptr_access = 1'b0;
   logic        ptr_sel = 1'b0;
   logic [1:0]  ptr_mode = '0;
   logic        push = 1'b0, pop = 1'b0;
   logic        pc_inc = 1'b0, pc_load = 1'b0, pc_lo_load = 1'b0, irq_take = 1'b0;
   logic [14:0] pc_load_val = '0;
   logic [7:0]  pc_lo_val = '0;
   logic [7:0]  ram_addr;
   logic [14:0] pc;

   int checks = 0, errors = 0;
   int m_p[2];
   int m_sp, m_pc;

   always #10 clk = ~clk;

   ptr_stack_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr_access(ptr_access),
      .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .push(push), .pop(pop),
      .pc_inc(pc_inc), .pc_load(pc_load), .pc_load_val(pc_load_val),
      .pc_lo_load(pc_lo_load), .pc_lo_val(pc_lo_val), .irq_take(irq_take),
      .ram_addr(ram_addr), .pc(pc)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      reg_wr_en = 0; ptr_access = 0; ptr_mode = 0; push = 0; pop = 0;
      pc_inc = 0; pc_load = 0; pc_lo_load = 0; irq_take = 0;
   endtask

   // compare at mid-low phase, then advance the model across the rising edge
   task automatic cyc(string req);
      int e_addr, e_rd, n_sp, n_pc;
      int n_p[2];
      bit one_stk;
      #5;
      one_stk = push ^ pop;
      if (push && !pop)      e_addr = m_sp;
      else if (pop && !push) e_addr = (m_sp + 1) % 256;
      else                   e_addr = m_p[ptr_sel];
      case (reg_addr)
         2'd0: e_rd = m_p[0];
         2'd1: e_rd = m_p[1];
         2'd2: e_rd = m_sp;
         default: e_rd = 0;
      endcase
      chk(req, "ram_addr", int'(ram_addr), e_addr);
      chk(req, "reg_rdata", int'(reg_rdata), e_rd);
      chk(req, "pc", int'(pc), m_pc);
      n_sp = m_sp;
      if (push && !pop) n_sp = (m_sp + 255) % 256;
      if (pop && !push) n_sp = (m_sp + 1) % 256;
      if (reg_wr_en && reg_addr == 2) n_sp = reg_wdata;
      for (int i = 0; i < 2; i++) begin
         n_p[i] = m_p[i];
         if (ptr_access && !one_stk && ptr_sel == i[0]) begin
            if (ptr_mode == 2'b01) n_p[i] = (m_p[i] + 1) % 256;
            if (ptr_mode == 2'b10) n_p[i] = (m_p[i] + 255) % 256;
         end
         if (reg_wr_en && reg_addr == i[1:0]) n_p[i] = reg_wdata;
      end
      if (irq_take)        n_pc = 'h00FF;
      else if (pc_load)    n_pc = pc_load_val;
      else if (pc_lo_load) n_pc = (m_pc & 'h7F00) | pc_lo_val;
      else if (pc_inc)     n_pc = (m_pc + 1) % 32768;
      else                 n_pc = m_pc;
      @(posedge clk);
      m_sp = n_sp; m_pc = n_pc; m_p[0] = n_p[0]; m_p[1] = n_p[1];
      @(negedge clk);
      idle();
   endtask

   task automatic wr(int a, int d, string req);
      reg_wr_en = 1; reg_addr = a[1:0]; reg_wdata = d[7:0]; cyc(req);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_p[0] = 0; m_p[1] = 0; m_sp = 'h6F; m_pc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset values seen through every port
      reg_addr = 0; cyc("R1");
      reg_addr = 1; cyc("R1");
      reg_addr = 2; cyc("R1");
      // R2: register port map and unused code
      wr(0, 'h10, "R2"); wr(1, 'hF0, "R2"); wr(2, 'h40, "R2");
      wr(3, 'h55, "R2");
      for (int a = 0; a < 4; a++) begin reg_addr = a[1:0]; cyc("R2"); end
      // R3: post-step modes
      reg_addr = 0;
      for (int k = 0; k < 3; k++) begin ptr_access = 1; ptr_sel = 0; ptr_mode = 2'b01; cyc("R3"); end
      reg_addr = 1;
      for (int k = 0; k < 2; k++) begin ptr_access = 1; ptr_sel = 1; ptr_mode = 2'b10; cyc("R3"); end
      ptr_access = 1; ptr_sel = 1; ptr_mode = 2'b11; cyc("R3");
      ptr_access = 1; ptr_sel = 1; ptr_mode = 2'b00; cyc("R3");
      cyc("R3");
      // R4: wrap both ways
      wr(0, 'hFF, "R4"); reg_addr = 0; ptr_access = 1; ptr_sel = 0; ptr_mode = 2'b01; cyc("R4"); cyc("R4");
      wr(1, 'h00, "R4"); reg_addr = 1; ptr_access = 1; ptr_sel = 1; ptr_mode = 2'b10; cyc("R4"); cyc("R4");
      wr(2, 'h00, "R4"); reg_addr = 2; push = 1; cyc("R4"); cyc("R4");
      reg_addr = 2; pop = 1; cyc("R4"); cyc("R4");
      // R5: write beats step on the same pointer
      reg_wr_en = 1; reg_addr = 0; reg_wdata = 'h33; ptr_access = 1; ptr_sel = 0; ptr_mode = 2'b01; cyc("R5");
      reg_addr = 0; cyc("R5");
      reg_wr_en = 1; reg_addr = 2; reg_wdata = 'h20; push = 1; cyc("R5");
      reg_addr = 2; cyc("R5");
      // R6 / R7: push then pop
      reg_addr = 2;
      for (int k = 0; k < 3; k++) begin reg_addr = 2; push = 1; cyc("R6"); end
      for (int k = 0; k < 3; k++) begin reg_addr = 2; pop = 1; cyc("R7"); end
      reg_addr = 2; cyc("R7");
      // R8: access ignored during a stack op; clash leaves SP alone
      reg_addr = 0; push = 1; ptr_access = 1; ptr_sel = 0; ptr_mode = 2'b01; cyc("R8");
      reg_addr = 0; cyc("R8");
      reg_addr = 2; push = 1; pop = 1; ptr_access = 1; ptr_sel = 0; ptr_mode = 2'b01; cyc("R8");
      reg_addr = 2; cyc("R8");
      reg_addr = 0; cyc("R8");
      // R9: count and wrap
      for (int k = 0; k < 3; k++) begin pc_inc = 1; cyc("R9"); end
      pc_load = 1; pc_load_val = 15'h7FFF; cyc("R9");
      pc_inc = 1; cyc("R9"); cyc("R9");
      // R10: vector beats load and count
      pc_load = 1; pc_load_val = 15'h1234; cyc("R10");
      irq_take = 1; pc_load = 1; pc_inc = 1; pc_lo_load = 1; pc_lo_val = 8'h11; cyc("R10");
      cyc("R10");
      // R11: full and page-local loads and their order
      pc_load = 1; pc_load_val = 15'h5A5A; cyc("R11");
      pc_lo_load = 1; pc_lo_val = 8'hC3; pc_inc = 1; cyc("R11");
      pc_load = 1; pc_load_val = 15'h0102; pc_lo_load = 1; pc_lo_val = 8'h77; cyc("R11");
      cyc("R11");
      // mixed traffic across all paths
      for (int k = 0; k < 400; k++) begin
         reg_wr_en = ($urandom_range(0, 7) == 0);
         reg_addr = 2'($urandom_range(0, 3));
         reg_wdata = 8'($urandom);
         ptr_access = $urandom_range(0, 1) == 1;
         ptr_sel = $urandom_range(0, 1) == 1;
         ptr_mode = 2'($urandom_range(0, 3));
         push = ($urandom_range(0, 3) == 0);
         pop = ($urandom_range(0, 3) == 0);
         pc_inc = $urandom_range(0, 1) == 1;
         pc_load = ($urandom_range(0, 9) == 0);
         pc_load_val = 15'($urandom);
         pc_lo_load = ($urandom_range(0, 9) == 0);
         pc_lo_val = 8'($urandom);
         irq_take = ($urandom_range(0, 15) == 0);
         cyc("R3 R6 R7 R11");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule